// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block forms the byte that a parallel flash device returns when the host reads it while an internal program or erase runs, and in the short interval after that operation ends. The command decoder raises a busy flag once the last write strobe of a command sequence has been accepted. That is the fourth strobe for a byte program and the sixth for a sector or chip erase. It also presents the operation type and the byte being programmed. The array read path supplies the true stored byte. The host's qualified read pulse drives the toggle indication.

While an operation runs, the top two bits of the read byte carry status. The most significant bit is the polling bit: the inverted programmed bit during a program, and zero during an erase. The next bit flips on every host read. Once the busy flag drops, a settling window of a parameterised number of clock cycles follows. In that window only the polling bit already reflects the array, and the six low bits return a fixed filler pattern. After the window, the array byte passes through unchanged.

The control is a four-state machine. `ST_IDLE` is pass-through. `ST_PROG` is a program in progress and `ST_ERASE` is an erase in progress. `ST_SETTLE` is the post-completion window. The transitions are named as follows:
- **launch**: from `ST_IDLE` or `ST_SETTLE` to `ST_PROG` or `ST_ERASE` when busy is sampled high.
- **finish**: from a busy state to `ST_SETTLE` when busy is sampled low, or straight to `ST_IDLE` if the window length is zero.
- **expire**: from `ST_SETTLE` to `ST_IDLE` when the window count runs out.
- **hold**: every other case.

Top module: `flash_status_gen`

## Requirements
- R1: While reset is applied, and with no operation in progress after it, `rd_data` equals `array_data` on every bit.
- R2: After the clock edge at which busy is first sampled high with `op_erase` low, bit 7 of `rd_data` is the inverse of bit 7 of `prog_byte` as sampled at that edge. This holds until the operation ends.
- R3: After the clock edge at which busy is first sampled high with `op_erase` high, bit 7 of `rd_data` is 0 until the operation ends.
- R4: During an operation, bit 6 of `rd_data` is 0 after the launch edge. It inverts at each clock edge where `rd_strobe` is high, and only at those edges.
- R5: During an operation, bits 5..0 of `rd_data` equal `array_data[5:0]`.
- R6: After the edge at which busy is sampled low during an operation, the settling window lasts SETTLE_CYCLES clock cycles. During the window, bit 7 of `rd_data` equals `array_data[7]`, bit 6 holds its last toggle value regardless of `rd_strobe`, and bits 5..0 equal FILLER (default 6'b101010).
- R7: After the settling window ends, `rd_data` equals `array_data`, and `rd_strobe` has no effect on it.
- R8: Busy sampled high during the settling window launches a new operation at that edge, with bit 6 restarting at 0.
- R9: Changes of `prog_byte` after the launch edge do not affect bit 7 during the operation.
- R10: Changes of `op_erase` after the launch edge do not change the kind of operation reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | Internal program or erase in progress |
| op_erase | input | 1 | Operation type at launch: 1 = erase, 0 = program |
| prog_byte | input | 8 | Byte being programmed |
| rd_strobe | input | 1 | One-cycle pulse per qualified host read |
| array_data | input | 8 | True array byte at the read address |
| rd_data | output | 8 | Byte returned to the host |

## Verification
On every cycle, the assertions check the following: the erase polling bit stays low, the program polling bit is the inverse of the latched byte, the toggle bit flips on each read and holds otherwise, the toggle bit restarts at launch, the filler shows in the settling window, and the idle state passes the array byte through. Only the bench scenarios can show the length of the settling window counted from completion, a relaunch part-way through the window, and that `prog_byte` and `op_erase` are ignored mid-operation. The bench covers these by comparing every output bit against a cycle model built from the requirements.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROG   = 2'd1,
        ST_ERASE  = 2'd2,
        ST_SETTLE = 2'd3
    } fsw_state_e;
endpackage

// File: rtl/fsw_ctrl.sv
module fsw_ctrl
    import fsw_pkg::*;
#(
    parameter int SETTLE_CYCLES = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       op_erase,
    output fsw_state_e state_q,
    output logic       launch,
    output logic       in_op
);
    localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam int LOAD  = (SETTLE_CYCLES > 0) ? SETTLE_CYCLES - 1 : 0;
    localparam bit HAS_WINDOW = (SETTLE_CYCLES > 0);

    fsw_state_e state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: launch / finish / expire / hold
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (busy) state_d = op_erase ? ST_ERASE : ST_PROG;
            end
            ST_PROG, ST_ERASE: begin
                if (!busy) begin
                    state_d = HAS_WINDOW ? ST_SETTLE : ST_IDLE;
                    cnt_d   = CNT_W'(LOAD);
                end
            end
            ST_SETTLE: begin
                if (busy) begin
                    state_d = op_erase ? ST_ERASE : ST_PROG;
                end else if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        launch = busy && ((state_q == ST_IDLE) || (state_q == ST_SETTLE));
        in_op  = (state_q == ST_PROG) || (state_q == ST_ERASE);
    end
endmodule

// File: rtl/fsw_track.sv
module fsw_track (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic in_op,
    input  logic rd_strobe,
    input  logic prog_msb,
    output logic tgl_q,
    output logic poll_ref_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_q      <= 1'b0;
            poll_ref_q <= 1'b0;
        end else if (launch) begin
            tgl_q      <= 1'b0;
            poll_ref_q <= prog_msb;
        end else if (in_op && rd_strobe) begin
            tgl_q <= ~tgl_q;
        end
    end
endmodule

// File: rtl/fsw_mux.sv
module fsw_mux
    import fsw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-3:0] FILLER = '0
) (
    input  fsw_state_e        state_q,
    input  logic              tgl_q,
    input  logic              poll_ref_q,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int LOW_W = DATA_W - 2;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   rd_data = array_data;
            ST_PROG:   rd_data = {~poll_ref_q, tgl_q, array_data[LOW_W-1:0]};
            ST_ERASE:  rd_data = {1'b0, tgl_q, array_data[LOW_W-1:0]};
            ST_SETTLE: rd_data = {array_data[DATA_W-1], tgl_q, FILLER};
            default:   rd_data = array_data;
        endcase
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SETTLE_CYCLES = 125,
    parameter logic [DATA_W-3:0] FILLER = 6'b101010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              op_erase,
    input  logic [DATA_W-1:0] prog_byte,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    fsw_state_e state_q;
    logic launch;
    logic in_op;
    logic tgl_q;
    logic poll_ref_q;

    fsw_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
        .state_q(state_q), .launch(launch), .in_op(in_op)
    );

    fsw_track u_track (
        .clk(clk), .rst_n(rst_n), .launch(launch), .in_op(in_op),
        .rd_strobe(rd_strobe), .prog_msb(prog_byte[DATA_W-1]),
        .tgl_q(tgl_q), .poll_ref_q(poll_ref_q)
    );

    fsw_mux #(.DATA_W(DATA_W), .FILLER(FILLER)) u_mux (
        .state_q(state_q), .tgl_q(tgl_q), .poll_ref_q(poll_ref_q),
        .array_data(array_data), .rd_data(rd_data)
    );
endmodule

// File: rtl/fsw_checker.sv
module fsw_checker
    import fsw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-3:0] FILLER = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              op_erase,
    input logic [DATA_W-1:0] prog_byte,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] rd_data,
    input fsw_state_e        state_q,
    input logic              tgl_q
);
    logic idle_or_settle;
    logic op_run;
    assign idle_or_settle = (state_q == ST_IDLE) || (state_q == ST_SETTLE);
    assign op_run = (state_q == ST_PROG) || (state_q == ST_ERASE);

    assert_prog_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_or_settle && busy && !op_erase) |=> (rd_data[DATA_W-1] == !$past(prog_byte[DATA_W-1])));

    assert_erase_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_or_settle && busy && op_erase) |=> (rd_data[DATA_W-1] == 1'b0));

    assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_run && rd_strobe) |=> (tgl_q != $past(tgl_q)));

    assert_toggle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_run && !rd_strobe) |=> $stable(tgl_q));

    assert_settle_filler_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> (rd_data[DATA_W-3:0] == FILLER));

    assert_settle_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && !busy) |=> $stable(tgl_q));

    assert_idle_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (rd_data == array_data));

    assert_relaunch_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_or_settle && busy) |=> (rd_data[DATA_W-2] == 1'b0));
endmodule

bind flash_status_gen fsw_checker #(.DATA_W(DATA_W), .FILLER(FILLER)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
    .prog_byte(prog_byte), .rd_strobe(rd_strobe), .array_data(array_data),
    .rd_data(rd_data), .state_q(state_q), .tgl_q(tgl_q)
);

// File: tb/flash_status_gen_test.sv
`timescale 1ns/1ps
module flash_status_gen_test;
    localparam int SETTLE = 6;
    localparam logic [5:0] FILL = 6'b101010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy = 1'b0;
    logic op_erase = 1'b0;
    logic [7:0] prog_byte = 8'h00;
    logic rd_strobe = 1'b0;
    logic [7:0] array_data = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit in_reset = 1'b1;

    // model of the requirements: 0 idle, 1 program, 2 erase, 3 settle
    int m_st = 0;
    int m_cnt = 0;
    bit m_tgl = 1'b0;
    bit m_ref = 1'b0;
    bit m_fs = 1'b0;

    always #4 clk = ~clk;

    flash_status_gen #(.DATA_W(8), .SETTLE_CYCLES(SETTLE), .FILLER(FILL)) uut (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
        .prog_byte(prog_byte), .rd_strobe(rd_strobe),
        .array_data(array_data), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_tgl = 0; m_ref = 0; m_fs = 0;
        end else if (m_st == 0 || m_st == 3) begin
            if (busy) begin
                m_fs  = (m_st == 3);
                m_st  = op_erase ? 2 : 1;
                m_ref = prog_byte[7];
                m_tgl = 0;
            end else if (m_st == 3) begin
                if (m_cnt == 0) m_st = 0;
                else m_cnt = m_cnt - 1;
            end
        end else begin
            if (rd_strobe) m_tgl = ~m_tgl;
            if (!busy) begin
                m_st = 3;
                m_cnt = SETTLE - 1;
            end
        end
    end

    function automatic logic [7:0] exp_byte();
        case (m_st)
            1: return {~m_ref, m_tgl, array_data[5:0]};
            2: return {1'b0, m_tgl, array_data[5:0]};
            3: return {array_data[7], m_tgl, FILL};
            default: return array_data;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [7:0] e;
        string t7, t6, tl;
        e = exp_byte();
        case (m_st)
            1: begin t7 = "R2 R9"; t6 = m_fs ? "R8" : "R4"; tl = "R5"; end
            2: begin t7 = "R3 R10"; t6 = m_fs ? "R8" : "R4"; tl = "R5"; end
            3: begin t7 = "R6"; t6 = "R6"; tl = "R6"; end
            default: begin
                t7 = in_reset ? "R1" : "R7"; t6 = t7; tl = t7;
            end
        endcase
        chk({t7, " bit7"}, {7'd0, rd_data[7]}, {7'd0, e[7]});
        chk({t6, " bit6"}, {7'd0, rd_data[6]}, {7'd0, e[6]});
        chk({tl, " low"}, {2'd0, rd_data[5:0]}, {2'd0, e[5:0]});
    endtask

    task automatic cyc(input bit b, input bit er, input logic [7:0] pb,
                       input bit rs, input logic [7:0] ad);
        @(negedge clk);
        busy = b; op_erase = er; prog_byte = pb; rd_strobe = rs; array_data = ad;
        #1;
        check_all();
    endtask

    task automatic rnd_cyc(input bit b, input bit er);
        cyc(b, er, 8'($urandom), bit'($urandom % 2), 8'($urandom));
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state passes array data
        for (int i = 0; i < 4; i++) rnd_cyc(1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 3; i++) rnd_cyc(1'b0, 1'b0);
        in_reset = 1'b0;

        // directed program with 0x80, strobes, mid-op changes (R2 R4 R9 R10)
        cyc(1, 0, 8'h80, 0, 8'hFF);
        for (int i = 0; i < 6; i++) cyc(1, bit'(i % 2), 8'($urandom), bit'(i % 2 == 0), 8'($urandom));
        // finish, full settle window (R6), then idle with strobes (R7)
        for (int i = 0; i < SETTLE + 4; i++) cyc(0, 0, 8'h00, 1, 8'($urandom));

        // directed erase, relaunch in middle of settle (R3 R8)
        cyc(1, 1, 8'h00, 1, 8'h3C);
        for (int i = 0; i < 4; i++) cyc(1, 0, 8'hFF, 1, 8'($urandom));
        cyc(0, 0, 8'h00, 1, 8'hA5);
        cyc(0, 0, 8'h00, 0, 8'h5A);
        cyc(1, 0, 8'h00, 1, 8'h11);
        for (int i = 0; i < 3; i++) cyc(1, 1, 8'hFF, 1, 8'($urandom));
        for (int i = 0; i < SETTLE + 3; i++) cyc(0, 0, 8'h00, 0, 8'($urandom));

        // constrained random operations
        for (int op = 0; op < 300; op++) begin
            bit er;
            int len;
            int gap;
            er = bit'($urandom % 2);
            len = 1 + int'($urandom % 12);
            gap = int'($urandom % (SETTLE + 4));
            for (int i = 0; i < len; i++)
                rnd_cyc(1'b1, (i == 0) ? er : bit'($urandom % 2));
            for (int i = 0; i < gap; i++) rnd_cyc(1'b0, 1'b0);
        end
        for (int i = 0; i < SETTLE + 2; i++) rnd_cyc(1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule